// File: doc/BRIEF.md
# Adaptive-Threshold Hysteresis Slicer

This block turns a zero-centred, signed baseband envelope into a one-bit symbol stream. It uses a comparator with an upper and a lower threshold, and the output holds its level while the input sits between the two. Samples arrive with a valid strobe. The output level changes only on a valid sample. Each change of level raises a single-cycle edge strobe, which a downstream interval measurement can use.

The thresholds come from one of two sources, chosen by a mode input:

- **Fixed mode** takes the thresholds from configuration inputs.
- **Adaptive mode** derives them from a positive and a negative peak tracker. Each tracker jumps to the signal when the signal passes its held peak. Otherwise it decays toward zero by a right shift. The thresholds are centred on the mean of the two peaks and sit a quarter of the peak-to-peak value either side of it. Slicing therefore keeps working when the modulation depth or the DC offset drifts.

When the tracked amplitude is too small, the adaptive slicer holds its output rather than slicing noise.

Top module: `hyst_slicer`

## Requirements
- R1: After reset `sym_o` and `edge_o` are 0 and both tracked peaks are 0.
- R2: In fixed mode (`adapt_en_i`=0), a valid sample greater than `thr_hi_i` sets `sym_o` to 1 at the next clock edge. The test is strictly greater.
- R3: In fixed mode, a valid sample less than `thr_lo_i` clears `sym_o` at the next clock edge. A sample inside [`thr_lo_i`, `thr_hi_i`] leaves `sym_o` unchanged.
- R4: A cycle with `valid_i`=0 changes neither `sym_o` nor the tracked peaks, whatever `sample_i` carries.
- R5: On each valid sample the positive peak P becomes the sample if the sample is greater than P. Otherwise it becomes P - (P >>> DECAY_SH), using an arithmetic shift. The negative peak N uses the mirror rule: it takes the sample if the sample is less than N, and otherwise becomes N - (N >>> DECAY_SH).
- R6: In adaptive mode (`adapt_en_i`=1) the thresholds are built from the peaks after they include the current sample. The midpoint is M = floor((P+N)/2) and the offset is Q = floor((P-N)/4). The upper threshold is M+Q and the lower one is M-Q, and the compare rules of R2/R3 apply to them.
- R7: In adaptive mode, when P-N is not greater than MIN_PP, a valid sample leaves `sym_o` unchanged.
- R8: `edge_o` is 1 for exactly the one cycle in which `sym_o` shows a new value, and 0 otherwise.
- R9: The peaks are tracked in both modes. Switching to adaptive mode uses peaks built up while the block was in fixed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | DATA_W | Signed envelope sample |
| adapt_en_i | input | 1 | 1 selects adaptive thresholds, 0 selects fixed thresholds |
| thr_hi_i | input | DATA_W | Signed upper threshold for fixed mode |
| thr_lo_i | input | DATA_W | Signed lower threshold for fixed mode |
| sym_o | output | 1 | Current symbol level |
| edge_o | output | 1 | One-cycle strobe on each change of `sym_o` |

## Verification
The bench builds the block with DATA_W=12, DECAY_SH=3 and MIN_PP=64.

- **DATA_W=12** lets full-scale samples of +2047 and -2048 exercise the widest peak-to-peak span and the threshold arithmetic at its limits.
- **DECAY_SH=3** makes the peaks decay within a few samples, so amplitude and offset changes reach the adaptive thresholds inside short sequences.
- **MIN_PP=64** places the amplitude gate where a ±20 square wave stays held, while moderate signals on a large DC offset are sliced.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  typedef enum logic [1:0] {
    CMP_HOLD = 2'd0,
    CMP_SET  = 2'd1,
    CMP_CLR  = 2'd2
  } cmp_act_e;
endpackage

// File: rtl/slc_peak_track.sv
module slc_peak_track #(
  parameter int DATA_W   = 12,
  parameter int DECAY_SH = 3,
  parameter bit POS_PEAK = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [DATA_W-1:0] peak_next_o
);
  logic signed [DATA_W-1:0] peak_q;
  logic                     exceed;

  generate
    if (POS_PEAK) begin : g_pos
      assign exceed = sample_i > peak_q;
    end else begin : g_neg
      assign exceed = sample_i < peak_q;
    end
  endgenerate

  always_comb begin
    peak_next_o = peak_q;
    if (valid_i) begin
      if (exceed) peak_next_o = sample_i;
      else        peak_next_o = peak_q - (peak_q >>> DECAY_SH);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) peak_q <= '0;
    else         peak_q <= peak_next_o;
  end
endmodule

// File: rtl/slc_thresh.sv
module slc_thresh #(
  parameter int DATA_W = 12,
  parameter int MIN_PP = 64,
  localparam int TW    = DATA_W + 2
) (
  input  logic signed [DATA_W-1:0] pos_i,
  input  logic signed [DATA_W-1:0] neg_i,
  output logic signed [TW-1:0]     hi_o,
  output logic signed [TW-1:0]     lo_o,
  output logic                     amp_ok_o
);
  logic signed [TW-1:0] pos_x, neg_x, pp, sum, mid, quarter;

  assign pos_x    = {{2{pos_i[DATA_W-1]}}, pos_i};
  assign neg_x    = {{2{neg_i[DATA_W-1]}}, neg_i};
  assign pp       = pos_x - neg_x;
  assign sum      = pos_x + neg_x;
  assign mid      = sum >>> 1;
  assign quarter  = pp >>> 2;
  assign hi_o     = mid + quarter;
  assign lo_o     = mid - quarter;
  assign amp_ok_o = pp > $signed(TW'(MIN_PP));
endmodule

// File: rtl/slc_compare.sv
module slc_compare
  import slicer_pkg::*;
#(
  parameter int TW = 14
) (
  input  logic                 en_i,
  input  logic signed [TW-1:0] x_i,
  input  logic signed [TW-1:0] hi_i,
  input  logic signed [TW-1:0] lo_i,
  output cmp_act_e             act_o
);
  always_comb begin
    act_o = CMP_HOLD;
    if (en_i) begin
      if (x_i > hi_i)      act_o = CMP_SET;
      else if (x_i < lo_i) act_o = CMP_CLR;
    end
  end
endmodule

// File: rtl/hyst_slicer.sv
module hyst_slicer
  import slicer_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int DECAY_SH = 3,
  parameter int MIN_PP   = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic                     adapt_en_i,
  input  logic signed [DATA_W-1:0] thr_hi_i,
  input  logic signed [DATA_W-1:0] thr_lo_i,
  output logic                     sym_o,
  output logic                     edge_o
);
  localparam int TW = DATA_W + 2;

  logic signed [DATA_W-1:0] pos_nx, neg_nx;
  logic signed [TW-1:0]     a_hi, a_lo, hi_sel, lo_sel, x_ext;
  logic                     amp_ok, cmp_en;
  cmp_act_e                 act;
  logic                     sym_d;

  slc_peak_track #(.DATA_W(DATA_W), .DECAY_SH(DECAY_SH), .POS_PEAK(1'b1)) u_pk_pos (
    .clk_i, .rst_ni, .valid_i, .sample_i, .peak_next_o(pos_nx)
  );
  slc_peak_track #(.DATA_W(DATA_W), .DECAY_SH(DECAY_SH), .POS_PEAK(1'b0)) u_pk_neg (
    .clk_i, .rst_ni, .valid_i, .sample_i, .peak_next_o(neg_nx)
  );

  slc_thresh #(.DATA_W(DATA_W), .MIN_PP(MIN_PP)) u_thr (
    .pos_i(pos_nx), .neg_i(neg_nx), .hi_o(a_hi), .lo_o(a_lo), .amp_ok_o(amp_ok)
  );

  assign x_ext  = {{2{sample_i[DATA_W-1]}}, sample_i};
  assign hi_sel = adapt_en_i ? a_hi : {{2{thr_hi_i[DATA_W-1]}}, thr_hi_i};
  assign lo_sel = adapt_en_i ? a_lo : {{2{thr_lo_i[DATA_W-1]}}, thr_lo_i};
  assign cmp_en = valid_i && (!adapt_en_i || amp_ok);

  slc_compare #(.TW(TW)) u_cmp (
    .en_i(cmp_en), .x_i(x_ext), .hi_i(hi_sel), .lo_i(lo_sel), .act_o(act)
  );

  always_comb begin
    unique case (act)
      CMP_SET: sym_d = 1'b1;
      CMP_CLR: sym_d = 1'b0;
      default: sym_d = sym_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o  <= 1'b0;
      edge_o <= 1'b0;
    end else begin
      sym_o  <= sym_d;
      edge_o <= sym_d ^ sym_o;
    end
  end
endmodule

// File: rtl/hyst_slicer_chk.sv
module hyst_slicer_chk #(
  parameter int DATA_W = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic signed [DATA_W-1:0] sample_i,
  input logic                     adapt_en_i,
  input logic signed [DATA_W-1:0] thr_hi_i,
  input logic signed [DATA_W-1:0] thr_lo_i,
  input logic                     sym_o,
  input logic                     edge_o
);
  p_rst_low_r1: assert property (@(posedge clk_i) !rst_ni |=> !sym_o && !edge_o);

  p_fix_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !adapt_en_i && sample_i > thr_hi_i |=> sym_o);

  p_fix_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !adapt_en_i && sample_i < thr_lo_i && !(sample_i > thr_hi_i) |=> !sym_o);

  p_fix_band_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !adapt_en_i && sample_i >= thr_lo_i && sample_i <= thr_hi_i |=> $stable(sym_o));

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sym_o) && !edge_o);

  p_edge_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> sym_o != $past(sym_o));

  p_edge_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o || sym_o != $past(sym_o));
endmodule

bind hyst_slicer hyst_slicer_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/hyst_slicer_tb_top.sv
`timescale 1ns/1ps
module hyst_slicer_tb_top;
  localparam int DATA_W   = 12;
  localparam int DECAY_SH = 3;
  localparam int MIN_PP   = 64;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [DATA_W-1:0] sample_i = '0;
  logic adapt_en_i = 1'b0;
  logic signed [DATA_W-1:0] thr_hi_i = '0;
  logic signed [DATA_W-1:0] thr_lo_i = '0;
  logic sym_o, edge_o;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  integer m_pos = 0, m_neg = 0, m_sym = 0, m_edge = 0;

  always #2.5 clk_i = ~clk_i;

  hyst_slicer #(.DATA_W(DATA_W), .DECAY_SH(DECAY_SH), .MIN_PP(MIN_PP)) dut_i (
    .clk_i, .rst_ni, .valid_i, .sample_i, .adapt_en_i,
    .thr_hi_i, .thr_lo_i, .sym_o, .edge_o
  );

  task automatic check(string req, integer act, integer exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference update for one clock edge
  task automatic model_edge(bit v, integer s, bit adapt, integer hi_f, integer lo_f);
    integer hi, lo, nsym;
    bit en;
    nsym = m_sym;
    if (v) begin
      if (s > m_pos) m_pos = s; else m_pos = m_pos - (m_pos >>> DECAY_SH);
      if (s < m_neg) m_neg = s; else m_neg = m_neg - (m_neg >>> DECAY_SH);
      if (adapt) begin
        hi = ((m_pos + m_neg) >>> 1) + ((m_pos - m_neg) >>> 2);
        lo = ((m_pos + m_neg) >>> 1) - ((m_pos - m_neg) >>> 2);
        en = (m_pos - m_neg) > MIN_PP;
      end else begin
        hi = hi_f; lo = lo_f; en = 1'b1;
      end
      if (en) begin
        if (s > hi) nsym = 1;
        else if (s < lo) nsym = 0;
      end
    end
    m_edge = (nsym != m_sym) ? 1 : 0;
    m_sym = nsym;
  endtask

  task automatic step(bit v, integer s);
    valid_i  = v;
    sample_i = DATA_W'(s);
    @(posedge clk_i);
    model_edge(v, s, adapt_en_i, integer'(thr_hi_i), integer'(thr_lo_i));
    @(negedge clk_i);
    check(cur_req, integer'(sym_o), m_sym, "sym_o");
    check("R8", integer'(edge_o), m_edge, "edge_o");
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    m_pos = 0; m_neg = 0; m_sym = 0; m_edge = 0;
    check("R1", integer'(sym_o), 0, "sym_o in reset");
    check("R1", integer'(edge_o), 0, "edge_o in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();

    // fixed mode
    cur_req = "R2"; adapt_en_i = 1'b0; thr_hi_i = 100; thr_lo_i = -100;
    step(1, 50);   check("R3", integer'(sym_o), 0, "in-band hold");
    step(1, 100);  check("R2", integer'(sym_o), 0, "equal to hi not set");
    step(1, 150);  check("R2", integer'(sym_o), 1, "above hi sets");
    check("R8", integer'(edge_o), 1, "edge on rise");
    cur_req = "R3";
    step(1, 0);    check("R8", integer'(edge_o), 0, "edge one cycle");
    step(1, -100); check("R3", integer'(sym_o), 1, "equal to lo holds");
    step(1, -101); check("R3", integer'(sym_o), 0, "below lo clears");
    step(1, 100);  check("R3", integer'(sym_o), 0, "in-band hold low");
    step(1, 101);  check("R2", integer'(sym_o), 1, "just above hi");

    // invalid cycles ignored
    cur_req = "R4";
    for (int i = 0; i < 6; i++) step(0, (i % 2) ? -2048 : 2047);
    check("R4", integer'(sym_o), 1, "idle extremes ignored");
    step(1, 0); check("R4", integer'(sym_o), 1, "peaks untouched by idle");

    // switch to adaptive with peaks from fixed mode
    cur_req = "R9"; thr_hi_i = 2047; thr_lo_i = -2048;
    step(1, 400); step(1, -400);
    adapt_en_i = 1'b1;
    for (int i = 0; i < 12; i++) step(1, (i % 2) ? -300 : 300);

    // gated small amplitude after reset
    do_reset();
    cur_req = "R7";
    for (int i = 0; i < 16; i++) step(1, ((i / 2) % 2) ? -20 : 20);
    check("R7", integer'(sym_o), 0, "small amplitude held");

    // adaptive: offset square wave, changing depth
    cur_req = "R6";
    for (int i = 0; i < 24; i++) step(1, ((i / 3) % 2) ? 200 : 800);
    for (int i = 0; i < 24; i++) step(1, ((i / 4) % 2) ? -600 : 900);
    cur_req = "R5";
    for (int i = 0; i < 40; i++) step(1, ((i / 4) % 2) ? 80 : 180);
    for (int i = 0; i < 16; i++) step(1, ((i / 2) % 2) ? -2048 : 2047);
    for (int i = 0; i < 30; i++) step(1, ((i / 5) % 2) ? -30 : 30);
    for (int i = 0; i < 20; i++) step(i % 3 != 0, ((i / 2) % 2) ? -500 : 500);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule